// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block collects up to 63 level-sensitive interrupt sources and drives one interrupt request line to a CPU. Sources are numbered 1 to 63; number 0 stands for "no interrupt". Each source owns one enable bit and one pending bit. These bits live in two 32-bit register pairs, called high and low. A fixed per-source table sets which register and which bit belong to a source. The table is not a simple formula, so software must use the same table to find a source's bit.

Software uses a word-addressed register port. Through it, software reads and writes the enable masks, clears pending bits by writing ones, and reads a status word. The top six bits of that status word hold the number of the winning source. When several enabled sources are pending, the lowest source number wins.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset both mask registers read 0, `irq_o` is low, and the vector field reads 0.
- R2: Word address 0 is the high mask and address 1 is the low mask. Both are fully read/write, and a read returns the last value written.
- R3: A mask bit of 1 enables its source. With the bit at 0, the source still records pending, but it raises neither `irq_o` nor the vector.
- R4: A source held high for one clock sets its pending bit. The bit stays set after the source drops, until software clears it.
- R5: Address 2 (pending high) and address 3 (pending low) are write-one-to-clear. Bits written as 0 keep their value.
- R6: Sources are level-sensitive. A clear that lands while the source is still high leaves the bit set.
- R7: Each source maps to a fixed register and bit, where flat bit = 32*high + bit. Sources 1..15 map to low bits 15..1. Sources 16..18 map to high bits 2..0. Sources 19..30 map to high bits 14..3. Source 31 maps to high bit 15. Sources 32..47 map to low bits 31..16. Sources 48..63 map to high bits 16..31.
- R8: A read of address 4 returns the lowest-numbered pending-and-enabled source in bits 31:26, with bits 25:0 zero. The field is 0 when no such source exists.
- R9: `irq_o` is high exactly when some pending bit and its mask bit are both 1. It follows the registered state in the same cycle, with no added delay.
- R10: Read data appears on `rdata_o` after the clock edge that accepts the read. Addresses 5..7 read 0. Writes to addresses 4..7 change nothing. Input `src_i[0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Level source inputs, index = source number |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The assertions take two things for granted. First, a register request lasts exactly one cycle. Second, `src_i` changes only between clock edges, so each level seen at an edge is the one the bench meant to drive. The bench drives every input at the falling edge and holds each request for one cycle. It changes sources only while no request is in flight, except in the tests that deliberately make a clear and a held source meet.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned NUM_VEC = 64;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FLAT_W  = 2 * DATA_W;
  localparam int unsigned VEC_W   = $clog2(NUM_VEC);
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned IDX_W   = $clog2(FLAT_W);

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_HI = 3'd0,
    A_MASK_LO = 3'd1,
    A_PEND_HI = 3'd2,
    A_PEND_LO = 3'd3,
    A_VECTOR  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;  // flat position: 32*high + bit
  } vmap_t;

  // Fixed, non-linear source -> (register, bit) table
  function automatic vmap_t vmap_f(int unsigned v);
    vmap_t m;
    int unsigned hi;
    int unsigned bitn;
    m.valid = 1'b1;
    hi      = 0;
    bitn    = 0;
    if (v == 0) begin
      m.valid = 1'b0;
    end else if (v < 16) begin
      bitn = 16 - v;
    end else if (v < 19) begin
      hi   = 1;
      bitn = 18 - v;
    end else if (v < 31) begin
      hi   = 1;
      bitn = 33 - v;
    end else if (v == 31) begin
      hi   = 1;
      bitn = 15;
    end else if (v < 48) begin
      bitn = 63 - v;
    end else begin
      hi   = 1;
      bitn = v - 32;
    end
    m.idx = IDX_W'(hi * DATA_W + bitn);
    return m;
  endfunction
endpackage

// File: rtl/sirq_pend.sv
module sirq_pend
  import sirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_VEC-1:0] src_i,
  input  logic [FLAT_W-1:0] clr_i,
  output logic [FLAT_W-1:0] pend_o
);
  logic [FLAT_W-1:0] set_flat;
  logic [FLAT_W-1:0] pend_q;

  // route each source level to its scrambled flat position
  always_comb begin
    set_flat = '0;
    for (int unsigned v = 0; v < NUM_VEC; v++) begin
      vmap_t m;
      m = vmap_f(v);
      if (m.valid) set_flat[m.idx] = set_flat[m.idx] | src_i[v];
    end
  end

  // set wins over clear: level sources
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_flat;
  end

  assign pend_o = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0)); // R4
  AST_LEVEL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_flat) & ~pend_q) == '0)); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_flat)) == '0)); // R4
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
  import sirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAT_W-1:0] pend_i,
  input  logic [FLAT_W-1:0] mask_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              irq_o
);
  logic [FLAT_W-1:0]  live_flat;
  logic [NUM_VEC-1:0] act_vec;
  logic [NUM_VEC-1:0] below;

  assign live_flat = pend_i & mask_i;

  // back to source-number order
  always_comb begin
    act_vec = '0;
    for (int unsigned v = 0; v < NUM_VEC; v++) begin
      vmap_t m;
      m = vmap_f(v);
      if (m.valid) act_vec[v] = live_flat[m.idx];
    end
  end

  // lowest nonzero source number wins
  always_comb begin
    vec_o = '0;
    for (int v = NUM_VEC - 1; v > 0; v--) begin
      if (act_vec[v]) vec_o = VEC_W'(v);
    end
  end

  assign irq_o = |live_flat;

  assign below = (NUM_VEC'(1) << vec_o) - NUM_VEC'(1);

  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_o != '0)); // R9
  AST_WIN_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> act_vec[vec_o]); // R8
  AST_WIN_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((act_vec & below) == '0)); // R8
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [FLAT_W-1:0] pend_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [FLAT_W-1:0] mask_o,
  output logic [FLAT_W-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              wr, rd;
  logic [DATA_W-1:0] mask_hi_q, mask_lo_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_hi_q <= '0;
      mask_lo_q <= '0;
    end else if (wr) begin
      if (addr_i == A_MASK_HI) mask_hi_q <= wdata_i;
      if (addr_i == A_MASK_LO) mask_lo_q <= wdata_i;
    end
  end

  assign mask_o = {mask_hi_q, mask_lo_q};

  always_comb begin
    clr_o = '0;
    if (wr && addr_i == A_PEND_HI) clr_o[FLAT_W-1:DATA_W] = wdata_i;
    if (wr && addr_i == A_PEND_LO) clr_o[DATA_W-1:0]      = wdata_i;
  end

  always_comb begin
    case (addr_i)
      A_MASK_HI: rd_mux = mask_hi_q;
      A_MASK_LO: rd_mux = mask_lo_q;
      A_PEND_HI: rd_mux = pend_i[FLAT_W-1:DATA_W];
      A_PEND_LO: rd_mux = pend_i[DATA_W-1:0];
      A_VECTOR:  rd_mux = {vec_i, {(DATA_W-VEC_W){1'b0}}};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  AST_MASK_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == A_MASK_HI) |=> $stable(mask_hi_q)); // R2
  AST_MASK_LO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == A_MASK_LO) |=> $stable(mask_lo_q)); // R2
  AST_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o != '0) |-> (wr && (addr_i == A_PEND_HI || addr_i == A_PEND_LO))); // R5
  AST_VEC_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_VECTOR) |=> (rdata_o[DATA_W-VEC_W-1:0] == '0)); // R8
  AST_RD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [FLAT_W-1:0] mask_flat;
  logic [FLAT_W-1:0] pend_flat;
  logic [FLAT_W-1:0] clr_flat;
  logic [VEC_W-1:0]  vec_id;

  sirq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend_flat),
    .vec_i   (vec_id),
    .mask_o  (mask_flat),
    .clr_o   (clr_flat),
    .rdata_o (rdata_o)
  );

  sirq_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .clr_i  (clr_flat),
    .pend_o (pend_flat)
  );

  sirq_prio u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_flat),
    .mask_i (mask_flat),
    .vec_o  (vec_id),
    .irq_o  (irq_o)
  );

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_flat == '0) |-> !irq_o); // R3
endmodule

// File: tb/sirq_ctrl_tb.sv
`timescale 1ns/1ps
module sirq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  sirq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // expected flat position (32*high + bit) per R7
  function automatic int exp_idx(int v);
    if (v < 16) return 16 - v;
    if (v < 19) return 32 + 18 - v;
    if (v < 31) return 32 + 33 - v;
    if (v == 31) return 32 + 15;
    if (v < 48) return 63 - v;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic clear_all();
    src = '0;
    wr(3'd2, 32'hffff_ffff);
    wr(3'd3, 32'hffff_ffff);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ehi, elo;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(3'd0, d); chk("R1 mask hi", d, 0);
    rd(3'd1, d); chk("R1 mask lo", d, 0);
    rd(3'd4, d); chk("R1 vector", d, 0);
    chk("R1 irq", 32'(irq), 0);
    // R2
    wr(3'd0, 32'ha5c3_0f96); wr(3'd1, 32'h3c3c_e1d2);
    rd(3'd0, d); chk("R2 mask hi", d, 32'ha5c3_0f96);
    rd(3'd1, d); chk("R2 mask lo", d, 32'h3c3c_e1d2);
    wr(3'd0, 32'hffff_ffff); wr(3'd1, 32'hffff_ffff);
    rd(3'd1, d); chk("R2 mask lo ones", d, 32'hffff_ffff);
    // R10
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hdead_beef);
      rd(3'(a), d); chk("R10 unmapped", d, 0);
    end
    wr(3'd4, 32'hffff_ffff);
    rd(3'd4, d); chk("R10 vector write ignored", d, 0);
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk); chk("R10 src0 irq", 32'(irq), 0);
    rd(3'd2, d); chk("R10 src0 pend hi", d, 0);
    rd(3'd3, d); chk("R10 src0 pend lo", d, 0);
    src[0] = 1'b0;
    // R7/R4/R5/R6/R8/R9 per source sweep
    for (int v = 1; v < 64; v++) begin
      int ix;
      ix = exp_idx(v);
      ehi = (ix >= 32) ? (32'd1 << (ix - 32)) : 32'd0;
      elo = (ix < 32)  ? (32'd1 << ix) : 32'd0;
      @(negedge clk); src[v] = 1'b1;
      @(negedge clk);
      chk($sformatf("R9 irq v%0d", v), 32'(irq), 1);
      rd(3'd2, d); chk($sformatf("R7 pend hi v%0d", v), d, ehi);
      rd(3'd3, d); chk($sformatf("R7 pend lo v%0d", v), d, elo);
      rd(3'd4, d); chk($sformatf("R8 vector v%0d", v), d, 32'(v) << 26);
      wr((ix >= 32) ? 3'd2 : 3'd3, (ix >= 32) ? ehi : elo);
      rd((ix >= 32) ? 3'd2 : 3'd3, d);
      chk($sformatf("R6 level held v%0d", v), d, (ix >= 32) ? ehi : elo);
      src[v] = 1'b0;
      @(negedge clk);
      wr((ix >= 32) ? 3'd2 : 3'd3, ~((ix >= 32) ? ehi : elo));
      rd((ix >= 32) ? 3'd2 : 3'd3, d);
      chk($sformatf("R4 R5 kept v%0d", v), d, (ix >= 32) ? ehi : elo);
      wr((ix >= 32) ? 3'd2 : 3'd3, (ix >= 32) ? ehi : elo);
      chk($sformatf("R5 cleared irq v%0d", v), 32'(irq), 0);
    end
    // R8 priority over pairs
    for (int v = 1; v < 63; v++) begin
      int w, lo;
      w  = ((v * 37) % 63) + 1;
      lo = (v < w) ? v : w;
      @(negedge clk); src[v] = 1'b1; src[w] = 1'b1;
      @(negedge clk);
      rd(3'd4, d); chk($sformatf("R8 prio %0d,%0d", v, w), d, 32'(lo) << 26);
      clear_all();
    end
    // R3 masking, R9 combinational follow of mask
    for (int v = 1; v < 64; v += 7) begin
      int ix;
      ix = exp_idx(v);
      if (ix >= 32) wr(3'd0, ~(32'd1 << (ix - 32)));
      else          wr(3'd1, ~(32'd1 << ix));
      @(negedge clk); src[v] = 1'b1;
      @(negedge clk);
      chk($sformatf("R3 masked irq v%0d", v), 32'(irq), 0);
      rd(3'd4, d); chk($sformatf("R3 masked vec v%0d", v), d, 0);
      rd((ix >= 32) ? 3'd2 : 3'd3, d);
      chk($sformatf("R3 pend recorded v%0d", v), d >> ((ix >= 32) ? ix - 32 : ix) & 1, 1);
      @(negedge clk); req = 1; we = 1; addr = (ix >= 32) ? 3'd0 : 3'd1; wdata = '1;
      @(negedge clk); req = 0; we = 0;
      chk($sformatf("R9 irq after unmask v%0d", v), 32'(irq), 1);
      clear_all();
      wr(3'd0, '1); wr(3'd1, '1);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule